// File: doc/BRIEF.md
# Three-Channel Cascadable Timer

This block holds three identical up-counting timer channels behind one word-addressed register bus, together with two block-wide registers. Each channel counts either a per-channel count-enable strobe or the rising edges of an external input. It also drives a waveform output that is set and cleared by two compare values. A block-wide control register restarts all three channels in one cycle. A block-wide mode register chooses what feeds channel 1's external input.

When channel 0 is programmed to set its waveform at count 0 and clear it at half range, that waveform rises once each time channel 0 wraps. If channel 1 is then told to count it, channel 1 holds the number of channel-0 wraps. Together the two 16-bit channels form a free-running 32-bit count. Software reads such a count as upper half, lower half, then upper half again, and keeps the result only if the two upper reads agree. If the channel width parameter is already large enough, channel 0 serves alone as the timebase and channel 1 is left free.

Top module: `tri_timer_cascade`

## Requirements
- R1: After reset every count, compare value, mode bit and clock-enable flag is zero, all waveform outputs are low, and the block mode register reads 0.
- R2: `addr[3:2]` picks a window: 0, 1 and 2 are channels, 3 is the block. Inside a channel window, offset 0 reads the count and takes commands on write. Offset 1 is the mode register: write bit 0 = source select; read `{wave, enabled, source}` in bits 2..0. Offset 2 is the set-compare value and offset 3 is the clear-compare value. Both compare values read back what was written.
- R3: Command bit 0 enables counting and command bit 1 disables it; when both are written, disable wins. A disabled channel's count does not move.
- R4: With source select 0, an enabled channel adds one for each clock cycle its `tick` bit is high. It wraps from all ones to zero.
- R5: Command bit 2 triggers one channel: its count becomes 0 and its waveform goes low. The other channels are untouched.
- R6: Writing 1 to bit 0 of block offset 0 triggers all three channels in the same cycle.
- R7: On each increment the waveform goes low if the new count equals the clear-compare value. Otherwise it goes high if the new count equals the set-compare value. Otherwise it holds its level.
- R8: With source select 1, an enabled channel adds one per rising edge of its external input, after a two-flop synchroniser. Channels 0 and 2 use their own pins.
- R9: Block offset 1 bits [1:0] choose channel 1's external input: 1 = channel 0's waveform, 2 = pin `ext_clk[1]`, 0 or 3 = held low (no chaining).
- R10: With channel 0 set-compare 0 and clear-compare 0x8000, and block mode 1, channel 1 counts channel-0 wraps. The pair {channel 1, channel 0} therefore forms a 32-bit count.
- R11: Under block mode 0 or 3, toggling `ext_clk[1]` leaves channel 1's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 3 | Per-channel internal count strobe |
| ext_clk | input | 3 | Per-channel external count inputs (bit 1 only via block mode) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address: window in [3:2], offset in [1:0] |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data, valid the cycle after `rd_en` |
| rd_valid | output | 1 | Read data qualifier |
| wave | output | 3 | Per-channel waveform outputs |

## Verification
Several properties are checked on every cycle. A disabled channel holds its count, and an enabled step adds exactly one. A trigger leaves the count at zero with the waveform low, and a sync write zeroes all three counts. A waveform that rises sits on its set-compare value, and the edge detector never pulses two cycles in a row. Other behaviour only the bench scenarios can show: the register map and readback, disable winning over enable, the chain source selection and pin isolation, and the carry from the lower to the upper half across a real wrap, read with the upper-lower-upper sequence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [1:0] OFF_CNT    = 2'd0;
    localparam logic [1:0] OFF_MODE   = 2'd1;
    localparam logic [1:0] OFF_SETCMP = 2'd2;
    localparam logic [1:0] OFF_CLRCMP = 2'd3;

    localparam logic [1:0] WIN_BLOCK  = 2'd3;
    localparam logic [1:0] BOFF_CTRL  = 2'd0;
    localparam logic [1:0] BOFF_MODE  = 2'd1;

    typedef enum logic [1:0] {
        CH1_SRC_OFF   = 2'd0,
        CH1_SRC_CHAIN = 2'd1,
        CH1_SRC_PIN   = 2'd2,
        CH1_SRC_OFF2  = 2'd3
    } ch1_src_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[1] & ~sh_q[2];

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_off,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    input  logic             ext_in,
    input  logic             trig_all,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] set_cmp,
    output logic [CNT_W-1:0] clr_cmp,
    output logic             src_sel,
    output logic             enabled,
    output logic             wave
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] set_cmp;
        logic [CNT_W-1:0] clr_cmp;
        logic             src_sel;
        logic             enabled;
        logic             wave;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic ext_rise;
    logic cmd_wr;
    logic trig;
    logic step;
    logic [CNT_W-1:0] cnt_next;

    tmr_edge_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .rise (ext_rise)
    );

    assign cmd_wr = wr_en && (wr_off == OFF_CNT);
    assign trig   = trig_all || (cmd_wr && wr_data[2]);

    always_comb begin
        st_d     = st_q;
        step     = st_q.enabled && (st_q.src_sel ? ext_rise : tick);
        cnt_next = st_q.cnt + CNT_W'(1);

        if (wr_en) begin
            case (wr_off)
                OFF_MODE:   st_d.src_sel = wr_data[0];
                OFF_SETCMP: st_d.set_cmp = wr_data;
                OFF_CLRCMP: st_d.clr_cmp = wr_data;
                default: ;
            endcase
        end
        if (cmd_wr && wr_data[0]) st_d.enabled = 1'b1;
        if (cmd_wr && wr_data[1]) st_d.enabled = 1'b0;

        if (trig) begin
            st_d.cnt  = '0;
            st_d.wave = 1'b0;
        end else if (step) begin
            st_d.cnt = cnt_next;
            if (cnt_next == st_q.clr_cmp)      st_d.wave = 1'b0;
            else if (cnt_next == st_q.set_cmp) st_d.wave = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign set_cmp = st_q.set_cmp;
    assign clr_cmp = st_q.clr_cmp;
    assign src_sel = st_q.src_sel;
    assign enabled = st_q.enabled;
    assign wave    = st_q.wave;

    assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.enabled && !trig) |=> $stable(st_q.cnt));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trig) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    assert_trigger_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (st_q.cnt == '0 && !st_q.wave));

    assert_rise_on_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.wave) && $stable(st_q.set_cmp)) |-> (st_q.cnt == st_q.set_cmp));
endmodule

// File: rtl/tri_timer_cascade.sv
module tri_timer_cascade #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       tick,
    input  logic [2:0]       ext_clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_valid,
    output logic [2:0]       wave
);
    import tmr_pkg::*;

    localparam int NCH = 3;

    typedef struct packed {
        ch1_src_e         ch1_src;
        logic [CNT_W-1:0] rdata;
        logic             rvalid;
    } blk_state_t;

    blk_state_t bs_d, bs_q;

    logic [1:0]       win;
    logic [1:0]       off;
    logic             sync_trig;
    logic [NCH-1:0]   ext_mux;
    logic [CNT_W-1:0] cnt_a     [NCH];
    logic [CNT_W-1:0] setc_a    [NCH];
    logic [CNT_W-1:0] clrc_a    [NCH];
    logic [NCH-1:0]   sel_a;
    logic [NCH-1:0]   en_a;
    logic [NCH-1:0]   wave_a;
    logic [CNT_W-1:0] rd_mux;

    assign win       = addr[3:2];
    assign off       = addr[1:0];
    assign sync_trig = wr_en && (win == WIN_BLOCK) && (off == BOFF_CTRL) && wr_data[0];

    always_comb begin
        ext_mux = ext_clk;
        case (bs_q.ch1_src)
            CH1_SRC_CHAIN: ext_mux[1] = wave_a[0];
            CH1_SRC_PIN:   ext_mux[1] = ext_clk[1];
            default:       ext_mux[1] = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (win == 2'(i))),
            .wr_off  (off),
            .wr_data (wr_data),
            .tick    (tick[i]),
            .ext_in  (ext_mux[i]),
            .trig_all(sync_trig),
            .cnt     (cnt_a[i]),
            .set_cmp (setc_a[i]),
            .clr_cmp (clrc_a[i]),
            .src_sel (sel_a[i]),
            .enabled (en_a[i]),
            .wave    (wave_a[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (win == WIN_BLOCK) begin
            if (off == BOFF_MODE) rd_mux = CNT_W'(bs_q.ch1_src);
        end else begin
            case (off)
                OFF_CNT:    rd_mux = cnt_a[win];
                OFF_MODE:   rd_mux = CNT_W'({wave_a[win], en_a[win], sel_a[win]});
                OFF_SETCMP: rd_mux = setc_a[win];
                default:    rd_mux = clrc_a[win];
            endcase
        end
    end

    always_comb begin
        bs_d        = bs_q;
        bs_d.rvalid = rd_en;
        if (rd_en) bs_d.rdata = rd_mux;
        if (wr_en && (win == WIN_BLOCK) && (off == BOFF_MODE))
            bs_d.ch1_src = ch1_src_e'(wr_data[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign rd_data  = bs_q.rdata;
    assign rd_valid = bs_q.rvalid;
    assign wave     = wave_a;

    assert_sync_zeroes_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_trig |=> (cnt_a[0] == '0 && cnt_a[1] == '0 && cnt_a[2] == '0));

    assert_read_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: tb/tri_timer_cascade_test.sv
`timescale 1ns/1ps
module tri_timer_cascade_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   tick;
    logic [2:0]   ext_clk;
    logic         wr_en, rd_en;
    logic [3:0]   addr;
    logic [W-1:0] wr_data;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic [2:0]   wave;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    bit           chk_q [$];
    logic [W-1:0] last_rd;

    always #2.5 clk = ~clk;

    tri_timer_cascade #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_clk(ext_clk),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .wave(wave)
    );

    // monitor: pops the scoreboard whenever read data comes back
    always @(negedge clk) begin
        if (rd_valid) begin
            last_rd = rd_data;
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R2: unexpected read data %h, expected none", rd_data);
            end else begin
                logic [W-1:0] e; string t; bit c;
                e = exp_q.pop_front(); t = tag_q.pop_front(); c = chk_q.pop_front();
                if (c) begin
                    n_vec++;
                    if (rd_data !== e) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", t, rd_data, e);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [W-1:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(1'b1);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_raw(input logic [3:0] a, output logic [W-1:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back('0); tag_q.push_back("raw"); chk_q.push_back(1'b0);
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        v = last_rd;
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] e, input string t);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic tick_n(input int ch, input int n);
        @(negedge clk);
        tick[ch] = 1'b1;
        repeat (n) @(negedge clk);
        tick[ch] = 1'b0;
    endtask

    task automatic ext_pulse(input int ch);
        @(negedge clk); ext_clk[ch] = 1'b1;
        repeat (3) @(negedge clk); ext_clk[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] hi1, lo, hi2;
        rst_n = 1'b0; tick = '0; ext_clk = '0; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(4'h0, 16'h0, "R1 ch0 count");
        rd_chk(4'hB, 16'h0, "R1 ch2 clear-compare");
        rd_chk(4'hD, 16'h0, "R1 block mode");
        rd_chk(4'h5, 16'h0, "R1 ch1 status");
        chk(W'(wave), 16'h0, "R1 waves low");

        // R2 register readback
        wr(4'hA, 16'h0003);
        wr(4'hB, 16'h0006);
        rd_chk(4'hA, 16'h0003, "R2 set-compare readback");
        rd_chk(4'hB, 16'h0006, "R2 clear-compare readback");
        wr(4'h5, 16'h0001);
        rd_chk(4'h5, 16'h0001, "R2 ch1 mode source bit");

        // R3 disabled channel ignores ticks
        tick_n(2, 4);
        rd_chk(4'h8, 16'h0, "R3 disabled ch2 holds");

        // R4 internal counting on ch0
        wr(4'h0, 16'h0001);
        tick_n(0, 5);
        rd_chk(4'h0, 16'h0005, "R4 ch0 five ticks");

        // R7 set on reaching set-compare
        wr(4'h8, 16'h0001);
        rd_chk(4'h9, 16'h0002, "R3 ch2 enabled status");
        tick_n(2, 3);
        chk(W'(wave[2]), 16'h1, "R7 wave set at set-compare");

        // R5 single-channel trigger
        wr(4'h8, 16'h0004);
        rd_chk(4'h8, 16'h0, "R5 ch2 count zeroed");
        chk(W'(wave[2]), 16'h0, "R5 wave low after trigger");
        rd_chk(4'h0, 16'h0005, "R5 ch0 untouched");

        tick_n(2, 4);
        chk(W'(wave[2]), 16'h1, "R7 wave set again");
        tick_n(2, 2);
        chk(W'(wave[2]), 16'h0, "R7 wave cleared at clear-compare");
        rd_chk(4'h8, 16'h0006, "R4 ch2 count six");

        // R3 disable wins over enable
        wr(4'h8, 16'h0003);
        rd_chk(4'h9, 16'h0000, "R3 disable wins");
        tick_n(2, 2);
        rd_chk(4'h8, 16'h0006, "R3 disabled count frozen");

        // R8/R9 channel 1 from pin (block mode 2)
        wr(4'hD, 16'h0002);
        rd_chk(4'hD, 16'h0002, "R9 block mode readback");
        wr(4'h4, 16'h0001);
        ext_pulse(1); ext_pulse(1); ext_pulse(1);
        rd_chk(4'h4, 16'h0003, "R8 three pin edges");

        // R11 pin isolated under modes 0 and 3
        wr(4'hD, 16'h0000);
        ext_pulse(1); ext_pulse(1);
        rd_chk(4'h4, 16'h0003, "R11 mode 0 ignores pin");
        wr(4'hD, 16'h0003);
        ext_pulse(1);
        rd_chk(4'h4, 16'h0003, "R11 mode 3 ignores pin");

        // R6 sync restarts all channels
        wr(4'hC, 16'h0001);
        rd_chk(4'h0, 16'h0, "R6 ch0 zero");
        rd_chk(4'h4, 16'h0, "R6 ch1 zero");
        rd_chk(4'h8, 16'h0, "R6 ch2 zero");

        // R10 chained 32-bit count
        wr(4'h2, 16'h0000);
        wr(4'h3, 16'h8000);
        wr(4'hD, 16'h0001);
        wr(4'hC, 16'h0001);
        tick_n(0, 65535);
        repeat (6) @(negedge clk);
        rd_raw(4'h4, hi1); rd_raw(4'h0, lo); rd_raw(4'h4, hi2);
        chk(hi1, hi2, "R10 upper reads agree before wrap");
        chk(lo, 16'hFFFF, "R4 lower at all ones");
        chk(hi1, 16'h0000, "R10 upper zero before wrap");
        tick_n(0, 1);
        repeat (6) @(negedge clk);
        rd_raw(4'h4, hi1); rd_raw(4'h0, lo); rd_raw(4'h4, hi2);
        chk(lo, 16'h0000, "R4 lower wraps to zero");
        chk(hi1, 16'h0001, "R10 upper carries on wrap");
        chk(W'(wave[0]), 16'h1, "R7 ch0 wave high after wrap");
        tick_n(0, 1000);
        repeat (6) @(negedge clk);
        rd_raw(4'h4, hi1); rd_raw(4'h0, lo); rd_raw(4'h4, hi2);
        chk(hi1, hi2, "R10 upper reads agree");
        chk({hi1, lo}, 32'h0001_03E8, "R10 32-bit count");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule